// File: doc/BRIEF.md
# Clustered parity error-detecting register

This block is a bank of data flip-flops guarded by parity. The bits are split into equal clusters. Every cluster keeps one extra flip-flop that holds the even parity of its data bits. That parity is formed from the incoming word, so it is stored on the same clock edge as the data. A check tree then watches each cluster's stored bits, data and parity together. Any cluster whose stored bits have odd weight raises its own flag. The flags are OR-reduced into one summary error.

Parity generation is the only logic placed in series with the functional path. The check and the reduction hang off the register outputs, in parallel with whatever logic consumes the data. All three reductions are built as trees of 3-input gates, with depth ceil(log3 n). The block only detects errors. It does not correct them, scrub the bank or rewrite it. Its user sets `CL_SIZE`, the number of flip-flops per cluster including the parity bit, and `N_CL`, the number of clusters. The data width is therefore (`CL_SIZE`-1)×`N_CL`.

Top module: `parity_cluster_reg`

## Requirements
- R1: While `rst_ni` is low, `data_o` is all zeros, every bit of `cl_err_o` is 0 and `err_o` is 0.
- R2: After reset, `data_o` equals the `data_i` value sampled at the previous rising edge of `clk_i`. Cluster c owns data bits [c×(CL_SIZE-1) +: CL_SIZE-1].
- R3: Each cluster's parity flip-flop loads the XOR of that cluster's incoming data bits on the same edge as the data. As a result, no cluster flag rises for any input pattern when the stored bits are undisturbed.
- R4: A single inverted stored bit in cluster c, whether a data bit or the parity bit, sets `cl_err_o[c]` and leaves every other flag bit at 0.
- R5: `err_o` is 1 exactly when at least one bit of `cl_err_o` is 1.
- R6: Two inverted stored bits within the same cluster produce no flag, because even parity is blind to even-weight errors.
- R7: The flags are combinational from the stored bits. They follow a disturbance with no clock edge in between, and they clear once the next edge loads fresh, consistent data.
- R8: Single inversions in two different clusters at the same time raise both of those flag bits and no others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| data_i | input | (CL_SIZE-1)*N_CL | Next-state data word |
| data_o | output | (CL_SIZE-1)*N_CL | Registered data, parity stripped |
| cl_err_o | output | N_CL | Per-cluster parity mismatch flags |
| err_o | output | 1 | OR of all cluster flags |

## Verification
The bench disturbs stored flip-flops directly and targets several corner cases:

- **Cluster ends.** It flips bits in the first, a middle and the last cluster, and both the lowest and highest data bit of a cluster. A slice-indexing slip would show up here as the wrong flag bit, or no flag at all.
- **Parity flip-flop alone.** It inverts only the parity flip-flop. A check tree that ignored the stored parity would then stay silent.
- **Double flips.** It applies two flips in one cluster. A design that is not truly even-parity, for example one that ORs the bits instead of XORing them, would raise a flag there.
- **Flips in two clusters.** It applies flips in two separate clusters at once. A reduction that does not combine every leaf would then miss one of them.
- **Fault-free stream.** Dense and sparse data words run with no faults at all. Here a parity generator taken from the wrong bits would raise false flags.

// File: rtl/pcr_pkg.sv
package pcr_pkg;

  typedef enum logic {
    TREE_XOR = 1'b0,
    TREE_OR  = 1'b1
  } tree_op_e;

  // depth of a 3-input tree over n leaves
  function automatic int unsigned clog3(input int unsigned n);
    int unsigned d;
    int unsigned p;
    d = 0;
    p = 1;
    while (p < n) begin
      p = p * 3;
      d = d + 1;
    end
    return d;
  endfunction

  // nodes left after l levels of 3:1 reduction
  function automatic int unsigned lvl_w(input int unsigned n, input int unsigned l);
    int unsigned w;
    w = n;
    for (int unsigned i = 0; i < l; i++) w = (w + 2) / 3;
    return w;
  endfunction

endpackage

// File: rtl/pcr_tree3.sv
module pcr_tree3
  import pcr_pkg::*;
#(
  parameter int unsigned N  = 3,
  parameter tree_op_e    OP = TREE_XOR
) (
  input  logic [N-1:0] in_i,
  output logic         out_o
);

  localparam int unsigned DEPTH = clog3(N);

  wire [DEPTH:0][N-1:0] lvl;

  assign lvl[0] = in_i;

  for (genvar l = 0; l < DEPTH; l++) begin : g_lvl
    localparam int unsigned WI = lvl_w(N, l);
    localparam int unsigned WO = lvl_w(N, l + 1);

    // pad with zeros: identity for both xor and or
    logic [3*WO-1:0] pad;
    always_comb begin
      pad = '0;
      pad[WI-1:0] = lvl[l][WI-1:0];
    end

    for (genvar k = 0; k < WO; k++) begin : g_node
      if (OP == TREE_OR) begin : g_or
        assign lvl[l+1][k] = |pad[3*k +: 3];
      end else begin : g_xor
        assign lvl[l+1][k] = ^pad[3*k +: 3];
      end
    end

    if (WO < N) begin : g_fill
      assign lvl[l+1][N-1:WO] = '0;
    end
  end

  assign out_o = lvl[DEPTH][0];

  logic unused_nodes;
  assign unused_nodes = ^lvl;

endmodule

// File: rtl/pcr_cluster.sv
module pcr_cluster
  import pcr_pkg::*;
#(
  parameter int unsigned S = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [S-2:0] d_i,
  output logic [S-2:0] q_o,
  output logic         err_o
);

  localparam int unsigned DB = S - 1;

  logic          par_d;
  logic [DB-1:0] data_q;
  logic          par_q;

  // serial overhead: parity formed ahead of the flops
  pcr_tree3 #(
    .N  (DB),
    .OP (TREE_XOR)
  ) i_gen (
    .in_i  (d_i),
    .out_o (par_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      par_q  <= 1'b0;
    end else begin
      data_q <= d_i;
      par_q  <= par_d;
    end
  end

  // parallel check over all S stored bits
  pcr_tree3 #(
    .N  (S),
    .OP (TREE_XOR)
  ) i_chk (
    .in_i  ({par_q, data_q}),
    .out_o (err_o)
  );

  assign q_o = data_q;

endmodule

// File: rtl/parity_cluster_reg.sv
module parity_cluster_reg
  import pcr_pkg::*;
#(
  parameter int unsigned CL_SIZE = 9,
  parameter int unsigned N_CL    = 9
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [(CL_SIZE-1)*N_CL-1:0]     data_i,
  output logic [(CL_SIZE-1)*N_CL-1:0]     data_o,
  output logic [N_CL-1:0]                 cl_err_o,
  output logic                            err_o
);

  localparam int unsigned DB = CL_SIZE - 1;
  localparam int unsigned DW = DB * N_CL;

  for (genvar c = 0; c < N_CL; c++) begin : g_cl
    pcr_cluster #(
      .S (CL_SIZE)
    ) i_cl (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (data_i[c*DB +: DB]),
      .q_o    (data_o[c*DB +: DB]),
      .err_o  (cl_err_o[c])
    );
  end

  pcr_tree3 #(
    .N  (N_CL),
    .OP (TREE_OR)
  ) i_red (
    .in_i  (cl_err_o),
    .out_o (err_o)
  );

endmodule

// File: rtl/parity_cluster_reg_chk.sv
module parity_cluster_reg_chk #(
  parameter int unsigned DW = 72,
  parameter int unsigned NC = 9
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [DW-1:0] data_i,
  input logic [DW-1:0] data_o,
  input logic [NC-1:0] cl_err_o,
  input logic          err_o
);

  logic live_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) live_q <= 1'b0;
    else         live_q <= 1'b1;
  end

  AST_RESET_STATE: assert property (@(posedge clk_i)
    !rst_ni |-> (data_o == '0 && cl_err_o == '0 && !err_o)); // R1

  AST_DATA_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q |-> data_o == $past(data_i)); // R2

  AST_ERR_HAS_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> cl_err_o != '0); // R5

  AST_SOURCE_RAISES_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cl_err_o != '0 |-> err_o); // R5

endmodule

bind parity_cluster_reg parity_cluster_reg_chk #(
  .DW (DW),
  .NC (N_CL)
) i_chk (.*);

// File: tb/test_parity_cluster_reg.sv
`timescale 1ns/1ps
module test_parity_cluster_reg;

  localparam int S  = 9;
  localparam int C  = 9;
  localparam int DB = S - 1;
  localparam int DW = DB * C;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [DW-1:0] data_i = '0;
  logic [DW-1:0] data_o;
  logic [C-1:0]  cl_err_o;
  logic          err_o;

  int n_cmp = 0;
  int n_bad = 0;
  logic [DW-1:0] exp_q = '0;

  always #5 clk_i = ~clk_i;

  parity_cluster_reg #(
    .CL_SIZE (S),
    .N_CL    (C)
  ) i_parity_cluster_reg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .data_i   (data_i),
    .data_o   (data_o),
    .cl_err_o (cl_err_o),
    .err_o    (err_o)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic chk_flags(input string req, input logic [C-1:0] exp);
    chk(req, DW'(cl_err_o), DW'(exp));
    chk({req, " R5"}, DW'(err_o), DW'(|exp));
  endtask

  // clock one word in, compare on the following falling edge
  task automatic step(input logic [DW-1:0] v);
    data_i = v;
    @(posedge clk_i);
    @(negedge clk_i);
    exp_q = v;
    chk("R2 data", data_o, exp_q);
    chk_flags("R3 no fault", '0);
  endtask

  function automatic logic [DW-1:0] rnd();
    logic [95:0] r;
    r = {$urandom, $urandom, $urandom};
    return r[DW-1:0];
  endfunction

  // fault hook: overwrite stored cluster bits (bench-only)
  task automatic set_bits(input int k, input logic [DB-1:0] d, input logic p);
    case (k)
      0: begin
        force i_parity_cluster_reg.g_cl[0].i_cl.data_q = d;
        force i_parity_cluster_reg.g_cl[0].i_cl.par_q  = p;
      end
      4: begin
        force i_parity_cluster_reg.g_cl[4].i_cl.data_q = d;
        force i_parity_cluster_reg.g_cl[4].i_cl.par_q  = p;
      end
      default: begin
        force i_parity_cluster_reg.g_cl[8].i_cl.data_q = d;
        force i_parity_cluster_reg.g_cl[8].i_cl.par_q  = p;
      end
    endcase
  endtask

  task automatic free_bits(input int k);
    case (k)
      0: begin
        release i_parity_cluster_reg.g_cl[0].i_cl.data_q;
        release i_parity_cluster_reg.g_cl[0].i_cl.par_q;
      end
      4: begin
        release i_parity_cluster_reg.g_cl[4].i_cl.data_q;
        release i_parity_cluster_reg.g_cl[4].i_cl.par_q;
      end
      default: begin
        release i_parity_cluster_reg.g_cl[8].i_cl.data_q;
        release i_parity_cluster_reg.g_cl[8].i_cl.par_q;
      end
    endcase
  endtask

  task automatic corrupt(input int k, input logic [DB-1:0] dm, input logic pf);
    logic [DB-1:0] cur;
    cur = exp_q[k*DB +: DB];
    set_bits(k, cur ^ dm, (^cur) ^ pf);
  endtask

  // put the good value back before releasing, then load fresh data
  task automatic repair(input int k);
    logic [DB-1:0] cur;
    cur = exp_q[k*DB +: DB];
    set_bits(k, cur, ^cur);
    #1;
    free_bits(k);
  endtask

  task automatic fault_case(input string req, input int k, input logic [DB-1:0] dm,
                            input logic pf, input logic [C-1:0] exp_flags);
    corrupt(k, dm, pf);
    #1;
    chk_flags(req, exp_flags);
    repair(k);
    step(rnd());
    chk_flags("R7 cleared", '0);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    data_i = rnd();
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk("R1 data reset", data_o, '0);
    chk_flags("R1 flags reset", '0);
    rst_ni = 1'b1;

    step('0);
    step('1);
    step({(DW/2){2'b10}});
    step({(DW/2){2'b01}});
    for (int i = 0; i < DW; i += 7) step(DW'(1) << i);
    for (int i = 0; i < 150; i++) step(rnd());

    // R4: single flips, edge clusters and edge bits
    fault_case("R4 c0 d3", 0, DB'(1) << 3, 1'b0, C'(1) << 0);
    fault_case("R4 c4 par", 4, '0, 1'b1, C'(1) << 4);
    fault_case("R4 c8 msb", 8, DB'(1) << (DB-1), 1'b0, C'(1) << 8);
    fault_case("R4 c0 lsb", 0, DB'(1), 1'b0, C'(1) << 0);

    // R6: even-weight errors are invisible
    fault_case("R6 c4 two data", 4, DB'(3) << 2, 1'b0, '0);
    fault_case("R6 c0 data+par", 0, DB'(1) << 5, 1'b1, '0);

    // R8: two clusters at once
    corrupt(0, DB'(1) << 1, 1'b0);
    corrupt(8, '0, 1'b1);
    #1;
    chk_flags("R8 c0+c8", (C'(1) << 0) | (C'(1) << 8));
    repair(0);
    repair(8);
    step(rnd());
    chk_flags("R7 cleared", '0);

    for (int i = 0; i < 20; i++) step(rnd());

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule